// File: doc/BRIEF.md
# Hot Method Profiling Tracker

This block runs next to a bytecode fetch path. It measures how much execution time each method uses, so that the busiest methods can be moved onto a reconfigurable coprocessor. Each fetch strobe carries the index of the method that owns the fetched bytecode. The tracker adds one to a saturating heat counter for that method. Heat builds up over every run of the method and is never reset when a new call starts.

The host sets three qualification flags for each method:
- the method can be built in hardware, either synthesizable or already pre-built;
- every object the method uses lives in shared memory;
- the method is recursive.

A method counts as eligible when it is buildable, uses only shared objects, is not recursive and has not been marked as mapped. From the eligible methods with nonzero heat, the tracker always reports the hottest one. On a tie, the lowest index wins.

The host works through one command port. It can write flags, mark a method as mapped, or clear all heat and mapped marks while the flags stay as they are. It reads the heat, flags and mapped mark of any entry combinationally, using the same index.

Top module: `hot_method_tracker`

## Requirements
- R1: A fetch strobe whose method index is below NUM_METHODS adds exactly one to that method's heat. The new value is visible on the first cycle after the clock edge that samples the strobe.
- R2: Heat keeps accumulating across separate bursts of fetches. It saturates at 2^HEAT_W-1 and stays there under further fetches.
- R3: A fetch strobe whose method index is NUM_METHODS or higher changes no counter.
- R4: The candidate output names the eligible method with the largest nonzero heat. When heats are equal, the lowest index is reported.
- R5: A method whose buildable flag (host_flags bit 0) is clear is never the candidate.
- R6: A method whose shared-objects flag (host_flags bit 1) is clear is never the candidate.
- R7: A method whose recursive flag (host_flags bit 2) is set is never the candidate.
- R8: Command 2 (mark mapped) sets the mapped mark of host_idx. A mapped method is never the candidate. The mark can be read on rd_mapped.
- R9: cand_valid is low, with cand_idx and cand_heat at zero, whenever no eligible method has nonzero heat.
- R10: Command 3 (clear) zeroes every heat counter and every mapped mark on the next edge. It keeps all flags and takes priority over a fetch in the same cycle.
- R11: After reset, all heats, flags and mapped marks are zero and cand_valid is low.
- R12: Command 1 (set flags) writes host_flags into entry host_idx. Reads of rd_heat, rd_flags and rd_mapped return that entry's state combinationally. If host_idx is out of range, writes are ignored and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | One bytecode fetched this cycle |
| fetch_idx | input | IDX_W | Method owning the fetched bytecode |
| host_op | input | 2 | Host command: 0 none, 1 set flags, 2 mark mapped, 3 clear |
| host_idx | input | IDX_W | Entry addressed by the command and by the read ports |
| host_flags | input | 3 | Flags to write: bit0 buildable, bit1 shared-objects, bit2 recursive |
| rd_heat | output | HEAT_W | Heat of entry host_idx |
| rd_flags | output | 3 | Flags of entry host_idx |
| rd_mapped | output | 1 | Mapped mark of entry host_idx |
| cand_valid | output | 1 | An eligible method with nonzero heat exists |
| cand_idx | output | $clog2(NUM_METHODS) | Index of the best candidate |
| cand_heat | output | HEAT_W | Heat of the best candidate |

## Verification
Some behaviour is checked by assertions on every cycle:
- the single-step increment and saturation hold of the counters;
- counter stability when no fetch is in range;
- that clear empties the table;
- that flags hold between writes;
- that the reported candidate is qualified, no eligible entry beats it, and ties resolve to the lower index.

Other behaviour only the directed scenarios can show:
- the exact heat values built up over several bursts;
- the effect of each flag taken alone;
- the order in which candidates move as methods are marked mapped;
- that clear wins over a fetch in the same cycle;
- that out-of-range host writes are dropped.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

    typedef struct packed {
        logic recursive;    // bit 2
        logic shared_only;  // bit 1
        logic mappable;     // bit 0
    } mflags_t;

    typedef enum logic [1:0] {
        HOP_NONE        = 2'd0,
        HOP_SET_FLAGS   = 2'd1,
        HOP_MARK_MAPPED = 2'd2,
        HOP_CLEAR       = 2'd3
    } hop_e;

    function automatic logic is_migratable(input mflags_t f, input logic mapped);
        return f.mappable & f.shared_only & ~f.recursive & ~mapped;
    endfunction

endpackage

// File: rtl/hmp_heat_bank.sv
module hmp_heat_bank #(
    parameter int NUM_METHODS = 16,
    parameter int HEAT_W      = 24,
    localparam int SEL_W      = $clog2(NUM_METHODS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              inc_en,
    input  logic [SEL_W-1:0]                  inc_sel,
    input  logic                              clr,
    input  logic                              map_en,
    input  logic [SEL_W-1:0]                  map_sel,
    output logic [NUM_METHODS-1:0][HEAT_W-1:0] heat_o,
    output logic [NUM_METHODS-1:0]            mapped_o
);
    localparam logic [HEAT_W-1:0] HEAT_MAX = '1;

    logic [NUM_METHODS-1:0][HEAT_W-1:0] heat_q;
    logic [NUM_METHODS-1:0]             mapped_q;

    for (genvar e = 0; e < NUM_METHODS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                heat_q[e]   <= '0;
                mapped_q[e] <= 1'b0;
            end else begin
                if (inc_en && inc_sel == SEL_W'(e) && heat_q[e] != HEAT_MAX)
                    heat_q[e] <= heat_q[e] + HEAT_W'(1);
                if (map_en && map_sel == SEL_W'(e))
                    mapped_q[e] <= 1'b1;
            end
        end
    end

    assign heat_o   = heat_q;
    assign mapped_o = mapped_q;

    // R1
    heat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !clr && heat_q[inc_sel] != HEAT_MAX)
        |=> heat_q[$past(inc_sel)] == $past(heat_q[inc_sel]) + HEAT_W'(1));

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_en && !clr && heat_q[inc_sel] == HEAT_MAX)
        |=> heat_q[$past(inc_sel)] == HEAT_MAX);

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc_en && !clr) |=> $stable(heat_q));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (heat_q == '0 && mapped_q == '0));

endmodule

// File: rtl/hmp_flag_bank.sv
module hmp_flag_bank
    import hmp_pkg::*;
#(
    parameter int NUM_METHODS = 16,
    localparam int SEL_W      = $clog2(NUM_METHODS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  mflags_t                     wr_flags,
    output mflags_t [NUM_METHODS-1:0]   flags_o
);
    mflags_t [NUM_METHODS-1:0] flags_q;

    for (genvar e = 0; e < NUM_METHODS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[e] <= '0;
            else if (wr_en && wr_sel == SEL_W'(e))
                flags_q[e] <= wr_flags;
        end
    end

    assign flags_o = flags_q;

    // R12 (also R10: a clear leaves the flags alone)
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flags_q));

endmodule

// File: rtl/hmp_best_finder.sv
module hmp_best_finder
    import hmp_pkg::*;
#(
    parameter int NUM_METHODS = 16,
    parameter int HEAT_W      = 24,
    localparam int SEL_W      = $clog2(NUM_METHODS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_METHODS-1:0][HEAT_W-1:0] heat_i,
    input  logic [NUM_METHODS-1:0]             mapped_i,
    input  mflags_t [NUM_METHODS-1:0]          flags_i,
    output logic                               cand_valid,
    output logic [SEL_W-1:0]                   cand_sel,
    output logic [HEAT_W-1:0]                  cand_heat
);
    logic [NUM_METHODS-1:0] elig;

    for (genvar e = 0; e < NUM_METHODS; e++) begin : g_elig
        assign elig[e] = is_migratable(flags_i[e], mapped_i[e]);
    end

    // Linear scan with strict compare: earlier (lower) index keeps ties.
    always_comb begin
        cand_valid = 1'b0;
        cand_sel   = '0;
        cand_heat  = '0;
        for (int e = 0; e < NUM_METHODS; e++) begin
            if (elig[e] && heat_i[e] > cand_heat) begin
                cand_valid = 1'b1;
                cand_sel   = SEL_W'(e);
                cand_heat  = heat_i[e];
            end
        end
    end

    for (genvar e = 0; e < NUM_METHODS; e++) begin : g_chk
        // R4
        none_hotter_chk: assert property (@(posedge clk) disable iff (rst)
            cand_valid |-> !(elig[e] && heat_i[e] > cand_heat));
        // R4
        tie_low_chk: assert property (@(posedge clk) disable iff (rst)
            (cand_valid && elig[e] && heat_i[e] == cand_heat) |-> cand_sel <= SEL_W'(e));
        // R9
        empty_chk: assert property (@(posedge clk) disable iff (rst)
            !cand_valid |-> !(elig[e] && heat_i[e] != '0));
    end

endmodule

// File: rtl/hot_method_tracker.sv
module hot_method_tracker
    import hmp_pkg::*;
#(
    parameter int NUM_METHODS = 16,
    parameter int HEAT_W      = 24,
    parameter int IDX_W       = 5,
    localparam int SEL_W      = $clog2(NUM_METHODS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [1:0]        host_op,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [2:0]        host_flags,
    output logic [HEAT_W-1:0] rd_heat,
    output logic [2:0]        rd_flags,
    output logic              rd_mapped,
    output logic              cand_valid,
    output logic [SEL_W-1:0]  cand_idx,
    output logic [HEAT_W-1:0] cand_heat
);
    hop_e op;
    logic fetch_in_range, host_in_range;
    logic [SEL_W-1:0] fetch_sel, host_sel;

    logic [NUM_METHODS-1:0][HEAT_W-1:0] heat;
    logic [NUM_METHODS-1:0]             mapped;
    mflags_t [NUM_METHODS-1:0]          flags;

    assign op             = hop_e'(host_op);
    assign fetch_in_range = int'(fetch_idx) < NUM_METHODS;
    assign host_in_range  = int'(host_idx) < NUM_METHODS;
    assign fetch_sel      = fetch_idx[SEL_W-1:0];
    assign host_sel       = host_idx[SEL_W-1:0];

    hmp_heat_bank #(.NUM_METHODS(NUM_METHODS), .HEAT_W(HEAT_W)) heat_bank_i (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (fetch_valid && fetch_in_range),
        .inc_sel  (fetch_sel),
        .clr      (op == HOP_CLEAR),
        .map_en   (op == HOP_MARK_MAPPED && host_in_range),
        .map_sel  (host_sel),
        .heat_o   (heat),
        .mapped_o (mapped)
    );

    hmp_flag_bank #(.NUM_METHODS(NUM_METHODS)) flag_bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (op == HOP_SET_FLAGS && host_in_range),
        .wr_sel   (host_sel),
        .wr_flags (mflags_t'(host_flags)),
        .flags_o  (flags)
    );

    hmp_best_finder #(.NUM_METHODS(NUM_METHODS), .HEAT_W(HEAT_W)) best_finder_i (
        .clk        (clk),
        .rst        (rst),
        .heat_i     (heat),
        .mapped_i   (mapped),
        .flags_i    (flags),
        .cand_valid (cand_valid),
        .cand_sel   (cand_idx),
        .cand_heat  (cand_heat)
    );

    always_comb begin
        rd_heat   = '0;
        rd_flags  = '0;
        rd_mapped = 1'b0;
        if (host_in_range) begin
            rd_heat   = heat[host_sel];
            rd_flags  = flags[host_sel];
            rd_mapped = mapped[host_sel];
        end
    end

    // R5 R6 R7 R8
    cand_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (flags[cand_idx].mappable && flags[cand_idx].shared_only
                        && !flags[cand_idx].recursive && !mapped[cand_idx]
                        && heat[cand_idx] == cand_heat && cand_heat != '0));

    // R9
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cand_valid |-> (cand_idx == '0 && cand_heat == '0));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!cand_valid && heat == '0 && mapped == '0 && flags == '0));

endmodule

// File: tb/hot_method_tracker_tb_top.sv
`timescale 1ns/1ps
module hot_method_tracker_tb_top;
    localparam int N  = 16;
    localparam int HW = 6;
    localparam int IW = 5;
    localparam int SW = $clog2(N);

    logic clk = 1'b0;
    logic rst;
    logic fetch_valid;
    logic [IW-1:0] fetch_idx;
    logic [1:0] host_op;
    logic [IW-1:0] host_idx;
    logic [2:0] host_flags;
    logic [HW-1:0] rd_heat;
    logic [2:0] rd_flags;
    logic rd_mapped;
    logic cand_valid;
    logic [SW-1:0] cand_idx;
    logic [HW-1:0] cand_heat;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hot_method_tracker #(.NUM_METHODS(N), .HEAT_W(HW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
        .host_op(host_op), .host_idx(host_idx), .host_flags(host_flags),
        .rd_heat(rd_heat), .rd_flags(rd_flags), .rd_mapped(rd_mapped),
        .cand_valid(cand_valid), .cand_idx(cand_idx), .cand_heat(cand_heat)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fetch(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            fetch_valid = 1'b1;
            fetch_idx   = IW'(idx);
            @(negedge clk);
        end
        fetch_valid = 1'b0;
    endtask

    task automatic host(input int op, input int idx, input int fl);
        host_op    = 2'(op);
        host_idx   = IW'(idx);
        host_flags = 3'(fl);
        @(negedge clk);
        host_op    = 2'd0;
    endtask

    task automatic peek(input int idx);
        host_idx = IW'(idx);
        #1;
    endtask

    task automatic expect_cand(input string tag, input bit v, input int idx, input int heat);
        chk(cand_valid == v, {tag, " valid"}, cand_valid, v);
        chk(cand_idx == SW'(idx), {tag, " idx"}, cand_idx, idx);
        chk(cand_heat == HW'(heat), {tag, " heat"}, cand_heat, heat);
    endtask

    task automatic t_reset;
        expect_cand("R11 reset", 1'b0, 0, 0);
        peek(3);
        chk(rd_heat == 0 && rd_flags == 0 && rd_mapped == 0, "R11 entry3 state", rd_heat, 0);
    endtask

    task automatic t_count;
        host(1, 2, 3);
        fetch(2, 5);
        peek(2);
        chk(rd_heat == 5, "R1 heat after 5 fetches", rd_heat, 5);
        expect_cand("R4 single eligible", 1'b1, 2, 5);
        fetch(2, 3);
        peek(2);
        chk(rd_heat == 8, "R2 accumulate second burst", rd_heat, 8);
    endtask

    task automatic t_out_of_range;
        fetch(20, 4);
        peek(2);
        chk(rd_heat == 8, "R3 oor fetch leaves entry2", rd_heat, 8);
        peek(4);
        chk(rd_heat == 0, "R3 oor fetch no alias entry4", rd_heat, 0);
        peek(20);
        chk(rd_heat == 0 && rd_flags == 0, "R12 oor read zero", rd_heat, 0);
        host(1, 20, 7);
        peek(4);
        chk(rd_flags == 0, "R12 oor write ignored", rd_flags, 0);
        expect_cand("R3 cand unchanged", 1'b1, 2, 8);
    endtask

    task automatic t_eligibility;
        host(1, 5, 1);
        fetch(5, 20);
        expect_cand("R6 no shared flag", 1'b1, 2, 8);
        host(1, 6, 2);
        fetch(6, 20);
        expect_cand("R5 no buildable flag", 1'b1, 2, 8);
        host(1, 7, 7);
        fetch(7, 20);
        expect_cand("R7 recursive", 1'b1, 2, 8);
        host(1, 5, 3);
        peek(5);
        chk(rd_flags == 3, "R12 flag readback", rd_flags, 3);
        expect_cand("R4 hottest after qualify", 1'b1, 5, 20);
    endtask

    task automatic t_tie;
        host(1, 9, 3);
        fetch(9, 20);
        expect_cand("R4 tie lowest index", 1'b1, 5, 20);
        fetch(9, 1);
        expect_cand("R4 tie broken", 1'b1, 9, 21);
    endtask

    task automatic t_mapped;
        host(2, 9, 0);
        peek(9);
        chk(rd_mapped == 1'b1, "R8 mapped readback", rd_mapped, 1);
        expect_cand("R8 mapped skipped", 1'b1, 5, 20);
        host(2, 5, 0);
        expect_cand("R8 next best", 1'b1, 2, 8);
        host(2, 2, 0);
        expect_cand("R9 none eligible", 1'b0, 0, 0);
    endtask

    task automatic t_clear;
        fetch_valid = 1'b1;
        fetch_idx   = IW'(2);
        host(3, 0, 0);
        fetch_valid = 1'b0;
        peek(2);
        chk(rd_heat == 0, "R10 clear beats fetch", rd_heat, 0);
        peek(9);
        chk(rd_mapped == 0 && rd_heat == 0, "R10 mapped cleared", rd_mapped, 0);
        peek(5);
        chk(rd_flags == 3, "R10 flags kept", rd_flags, 3);
        expect_cand("R9 all zero heat", 1'b0, 0, 0);
        fetch(5, 1);
        expect_cand("R10 restart count", 1'b1, 5, 1);
    endtask

    task automatic t_saturate;
        fetch(5, 70);
        peek(5);
        chk(rd_heat == 63, "R2 saturation", rd_heat, 63);
        expect_cand("R2 cand at max", 1'b1, 5, 63);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        fetch_valid = 1'b0;
        fetch_idx = '0;
        host_op = '0;
        host_idx = '0;
        host_flags = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_out_of_range();
        t_eligibility();
        t_tie();
        t_mapped();
        t_clear();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule